// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block produces the strobes and bus values that an 8-bit controller uses to reach external program and data memory. The memory bus shares one byte between the low address and the data. One clock of the block is one oscillator period. The address strobe pulses once in every six clocks. A code fetch takes one six-clock slot. A data read or a data write takes two slots, and the second slot has no address pulse. The high address byte is driven for the whole cycle. The shared low byte first carries the address. It then carries write data, or it is released so that the memory can drive it.

The core places a request with an opcode, an address and, for a write, a data byte. The request is taken at the single clock of a cycle in which `busy` is low. When no request is present at that point, the sequencer fetches the next code byte after the last fetched address. A fetch or a read ends with a one-clock `done` pulse that carries the captured byte. A write also ends with a `done` pulse.

The same block keeps a free-running twelve-clock machine-cycle count, starting from reset. It uses this count to sample the general-purpose port inputs and to update the port output register at fixed positions.

Top module: `xbus_sequencer`

## Requirements
- R1: `ale` is high for exactly 2 clocks in every slot that carries an address pulse. During code fetches, its rising edges are 6 clocks apart.
- R2: The low address is on `ad_out`, with `ad_oe` high, in the clock before `ale` falls and in the clock after it falls.
- R3: In a fetch, `psen_n` goes low 1 clock after the first low-`ale` clock and stays low for 3 clocks. During that time `ad_oe` is low and the high address byte equals the latched address.
- R4: A fetch captures `ad_in` on the last clock that `psen_n` is low. In the next clock, `done` pulses for one clock with `done_op` = 0 and `done_rdata` set to the captured byte.
- R5: In a read, `rd_n` goes low 3 clocks after `ale` falls and stays low for 6 clocks, with `ad_oe` low. `ad_in` is captured on the last low clock. In the next clock, `done` pulses with `done_op` = 1 and the byte.
- R6: In a write, `wr_n` goes low 3 clocks after `ale` falls and stays low for 6 clocks. The write byte is on `ad_out`, with `ad_oe` high, from 1 clock before `wr_n` falls until 1 clock after it rises. `done` pulses with `done_op` = 2.
- R7: A read or a write lasts 12 clocks and skips exactly one `ale` pulse. `ale` is never high while `rd_n` or `wr_n` is low.
- R8: `addr_hi` does not change while any strobe is low. It equals the high byte of the address that the cycle latched.
- R9: A request is taken only at a clock edge where `busy` is low. The next clock starts the new cycle with `ale` high. `req_op` uses 0 for fetch, 1 for read and 2 for write. The value 3 is treated as a fetch.
- R10: When no request is present at a cycle boundary, the sequencer fetches from the last fetched address plus one. The first fetch after reset reads address 0. An explicit fetch moves the sequence to its own address.
- R11: `port_pins` is sampled at the clock edge that ends machine-cycle position 9, where position 0 is the first clock after reset and positions count modulo 12. `port_smp` holds the sampled value until the next sample.
- R12: A byte written through `port_wr_en` / `port_wr_data` reaches `port_out` only at the edge that ends position 11. It appears at position 0.
- R13: During reset, `ale` is high, all strobes are high, `busy` is high and `done` is low. `port_out` resets to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 fetch, 1 read, 2 write |
| req_addr | input | AW | Request address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Low in the single clock where a request is taken |
| done | output | 1 | One-clock completion pulse |
| done_op | output | 2 | Opcode of the completed cycle |
| done_rdata | output | 8 | Byte captured by a fetch or a read |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | AW-8 | High address byte |
| ad_out | output | 8 | Shared low address / write data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 8 | Shared byte from memory |
| port_pins | input | PW | General-purpose port inputs |
| port_smp | output | PW | Last sampled port inputs |
| port_wr_en | input | 1 | Port output write request |
| port_wr_data | input | PW | New port output value |
| port_out | output | PW | Port output register |

## Verification
All bus timing is measured relative to the clock in which `ale` was last seen falling. The bench expects the fetch strobe 1 clock after that fall and the data strobes 3 clocks after it. Each `done` pulse is expected in the clock right after the last low strobe clock, and the bench confirms this by comparing the previous sample with the current one. Every sample is taken on the falling clock edge. Port behaviour is checked against a bench count of clocks since reset, modulo 12. The pins carry the test value only from the middle of position 9 to the middle of position 10, so sampling one clock early or one clock late is caught. The port output is expected to be unchanged at position 11 and updated at position 0.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    OP_FETCH = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } xop_e;

  // clocks per address-strobe slot and slots per machine cycle
  localparam int SLOT_LEN  = 6;
  localparam int SLOTS_MC  = 2;
  localparam int MC_LEN    = SLOT_LEN * SLOTS_MC;
  localparam int PH_W      = $clog2(SLOT_LEN);
  localparam int MC_W      = $clog2(MC_LEN);

  // offsets inside a slot (phase numbers)
  localparam int ALE_HI    = 2;  // ale high on phases 0..ALE_HI-1
  localparam int ADDR_LAST = 2;  // low address driven phases 0..ADDR_LAST
  localparam int PSEN_AT   = 3;  // fetch strobe phases PSEN_AT..SLOT_LEN-1
  localparam int DSTR_AT   = 5;  // data strobe start, first slot
  localparam int DSTR_LAST = 4;  // data strobe last phase, second slot

  // machine-cycle positions for the ports
  localparam int PORT_SMP_AT = 9;
  localparam int PORT_UPD_AT = 11;
endpackage

// File: rtl/xbus_timer.sv
module xbus_timer
  import xbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic [MC_W-1:0] mc,
  output logic            slot_last
);
  localparam logic [PH_W-1:0] PH_MAX = PH_W'(SLOT_LEN - 1);
  localparam logic [MC_W-1:0] MC_MAX = MC_W'(MC_LEN - 1);

  logic [PH_W-1:0] ph_q;
  logic [MC_W-1:0] mc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
      mc_q <= '0;
    end else begin
      ph_q <= (ph_q == PH_MAX) ? '0 : ph_q + 1'b1;
      mc_q <= (mc_q == MC_MAX) ? '0 : mc_q + 1'b1;
    end
  end

  assign ph        = ph_q;
  assign mc        = mc_q;
  assign slot_last = (ph_q == PH_MAX);

  // R11
  mc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_q == MC_MAX) |=> (mc_q == '0));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph,
  input  logic            slot_last,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [7:0]      req_wdata,
  input  logic [7:0]      ad_in,
  output logic            busy,
  output logic            done,
  output logic [1:0]      done_op,
  output logic [7:0]      done_rdata,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic [AW-9:0]   addr_hi,
  output logic [7:0]      ad_out,
  output logic            ad_oe
);
  localparam logic [PH_W-1:0] P_ALE   = PH_W'(ALE_HI);
  localparam logic [PH_W-1:0] P_ADDR  = PH_W'(ADDR_LAST);
  localparam logic [PH_W-1:0] P_PSEN  = PH_W'(PSEN_AT);
  localparam logic [PH_W-1:0] P_DSTR  = PH_W'(DSTR_AT);
  localparam logic [PH_W-1:0] P_DLAST = PH_W'(DSTR_LAST);
  localparam logic [PH_W-1:0] P_END   = PH_W'(SLOT_LEN - 1);

  xop_e          op_q, dop_q, req_kind;
  logic [AW-1:0] addr_q, fptr_q;
  logic [7:0]    wd_q, rdata_q;
  logic          seg_q, done_q;
  logic          cycle_end, cap_fetch, cap_data, first, addr_phase, dstrobe;

  always_comb begin
    case (req_op)
      2'd1:    req_kind = OP_READ;
      2'd2:    req_kind = OP_WRITE;
      default: req_kind = OP_FETCH;
    endcase
  end

  assign cycle_end = slot_last && ((op_q == OP_FETCH) || seg_q);
  assign cap_fetch = (op_q == OP_FETCH) && (ph == P_END);
  assign cap_data  = (op_q != OP_FETCH) && seg_q && (ph == P_DLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_FETCH;
      dop_q   <= OP_FETCH;
      addr_q  <= '0;
      fptr_q  <= AW'(1);
      wd_q    <= '0;
      rdata_q <= '0;
      seg_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cap_fetch || cap_data) begin
        done_q <= 1'b1;
        dop_q  <= op_q;
        if (op_q != OP_WRITE) rdata_q <= ad_in;
      end
      if (cycle_end) begin
        seg_q <= 1'b0;
        if (req_valid) begin
          op_q   <= req_kind;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          if (req_kind == OP_FETCH) fptr_q <= req_addr + 1'b1;
        end else begin
          op_q   <= OP_FETCH;
          addr_q <= fptr_q;
          fptr_q <= fptr_q + 1'b1;
        end
      end else if (slot_last) begin
        seg_q <= 1'b1;
      end
    end
  end

  // waveform decode from the cycle state flops
  assign first      = !seg_q;
  assign addr_phase = first && (ph <= P_ADDR);
  assign dstrobe    = (first && (ph == P_DSTR)) || (seg_q && (ph <= P_DLAST));

  assign ale        = first && (ph < P_ALE);
  assign psen_n     = !((op_q == OP_FETCH) && (ph >= P_PSEN));
  assign rd_n       = !((op_q == OP_READ) && dstrobe);
  assign wr_n       = !((op_q == OP_WRITE) && dstrobe);
  assign ad_oe      = addr_phase || (op_q == OP_WRITE);
  assign ad_out     = addr_phase ? addr_q[7:0] : wd_q;
  assign addr_hi    = addr_q[AW-1:8];
  assign busy       = !cycle_end;
  assign done       = done_q;
  assign done_op    = dop_q;
  assign done_rdata = rdata_q;

  // R1
  ale_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> ale ##1 !ale);
  // R3
  psen_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> (!$past(ale) && $past(ale, 2)));
  // R3
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe);
  // R7
  ale_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !ale);
  // R8
  addr_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n || !wr_n) |-> $stable(addr_hi));
  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));
  // R4
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!psen_n || !rd_n || !wr_n));
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!psen_n, !rd_n, !wr_n}));
endmodule

// File: rtl/xbus_port.sv
module xbus_port
  import xbus_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MC_W-1:0] mc,
  input  logic [PW-1:0]   pins,
  input  logic            wr_en,
  input  logic [PW-1:0]   wr_data,
  output logic [PW-1:0]   smp,
  output logic [PW-1:0]   pout
);
  localparam logic [MC_W-1:0] M_SMP  = MC_W'(PORT_SMP_AT);
  localparam logic [MC_W-1:0] M_UPD  = MC_W'(PORT_UPD_AT);
  localparam logic [MC_W-1:0] M_SEEN = MC_W'((PORT_SMP_AT + 1) % MC_LEN);
  localparam logic [MC_W-1:0] M_SHOW = MC_W'((PORT_UPD_AT + 1) % MC_LEN);

  logic [PW-1:0] smp_q, out_q, pend_d;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= '0;
      out_q  <= '1;
      pend_d <= '0;
      pend_q <= 1'b0;
    end else begin
      if (mc == M_SMP) smp_q <= pins;
      if ((mc == M_UPD) && pend_q) begin
        out_q  <= pend_d;
        pend_q <= 1'b0;
      end
      if (wr_en) begin
        pend_d <= wr_data;
        pend_q <= 1'b1;
      end
    end
  end

  assign smp  = smp_q;
  assign pout = out_q;

  // R11
  smp_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mc != M_SEEN) |-> $stable(smp_q));
  // R12
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mc != M_SHOW) |-> $stable(out_q));
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    done_op,
  output logic [7:0]    done_rdata,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-9:0] addr_hi,
  output logic [7:0]    ad_out,
  output logic          ad_oe,
  input  logic [7:0]    ad_in,
  input  logic [PW-1:0] port_pins,
  output logic [PW-1:0] port_smp,
  input  logic          port_wr_en,
  input  logic [PW-1:0] port_wr_data,
  output logic [PW-1:0] port_out
);
  logic [PH_W-1:0] ph;
  logic [MC_W-1:0] mc;
  logic            slot_last;

  xbus_timer u_tmr (
    .clk(clk), .rst(rst), .ph(ph), .mc(mc), .slot_last(slot_last)
  );

  xbus_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .ph(ph), .slot_last(slot_last),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .ad_in(ad_in), .busy(busy), .done(done),
    .done_op(done_op), .done_rdata(done_rdata), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  xbus_port #(.PW(PW)) u_port (
    .clk(clk), .rst(rst), .mc(mc), .pins(port_pins),
    .wr_en(port_wr_en), .wr_data(port_wr_data),
    .smp(port_smp), .pout(port_out)
  );
endmodule

// File: tb/sim_xbus_sequencer.sv
module sim_xbus_sequencer;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [1:0]  done_op;
  logic [7:0]  done_rdata, addr_hi, ad_out, ad_in;
  logic [7:0]  port_pins = '0, port_smp, port_wr_data = '0, port_out;
  logic        port_wr_en = 1'b0;

  xbus_sequencer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .done_op(done_op), .done_rdata(done_rdata), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .port_pins(port_pins),
    .port_smp(port_smp), .port_wr_en(port_wr_en),
    .port_wr_data(port_wr_data), .port_out(port_out)
  );

  int n_run = 0, n_fail = 0;
  int idx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  typedef struct {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
  } exp_t;
  exp_t q[$];

  // external memory model
  logic [15:0] lat_addr = '0;
  assign ad_in = (!psen_n || !rd_n) ? memf(lat_addr) : 8'h00;

  always @(posedge clk) idx <= rst ? 0 : idx + 1;

  // bus monitor and scoreboard
  logic        p_ale, p_psen, p_rd, p_wr, p_oe, seen_rise, gap_data;
  logic [7:0]  p_ad, wr_seen;
  logic [15:0] wr_addr_seen, last_fetch;
  int          ale_hi, since_fall, sw, last_rise;

  always @(negedge clk) begin
    if (rst) begin
      p_ale = 1; p_psen = 1; p_rd = 1; p_wr = 1; p_oe = 0; p_ad = 0;
      ale_hi = 0; since_fall = 0; sw = 0; seen_rise = 0; gap_data = 0;
      last_fetch = 16'hFFFF; last_rise = 0;
    end else begin
      if (ale) ale_hi++;
      if (ale && !p_ale) begin
        if (seen_rise)
          chk(idx - last_rise == (gap_data ? 12 : 6), gap_data ? "R7" : "R1",
              idx - last_rise, gap_data ? 12 : 6);
        seen_rise = 1; last_rise = idx; gap_data = 0;
      end
      if (!ale && p_ale) begin
        chk(ale_hi == 2, "R1", ale_hi, 2);
        ale_hi = 0;
        chk(ad_oe && p_oe && ad_out == p_ad, "R2", int'(ad_out), int'(p_ad));
        lat_addr = {addr_hi, ad_out};
        since_fall = 0;
      end else since_fall++;
      // fetch strobe
      if (!psen_n && p_psen) begin chk(since_fall == 1, "R3", since_fall, 1); sw = 0; end
      if (!psen_n) begin
        sw++;
        chk(!ad_oe, "R3", int'(ad_oe), 0);
        chk(addr_hi == lat_addr[15:8], "R8", int'(addr_hi), int'(lat_addr[15:8]));
      end
      if (psen_n && !p_psen) chk(sw == 3, "R3", sw, 3);
      // read strobe
      if (!rd_n && p_rd) begin chk(since_fall == 3, "R5", since_fall, 3); sw = 0; gap_data = 1; end
      if (!rd_n) begin
        sw++;
        chk(!ad_oe && !ale, "R5", int'({ad_oe, ale}), 0);
        chk(addr_hi == lat_addr[15:8], "R8", int'(addr_hi), int'(lat_addr[15:8]));
      end
      if (rd_n && !p_rd) chk(sw == 6, "R5", sw, 6);
      // write strobe
      if (!wr_n && p_wr) begin
        chk(since_fall == 3, "R6", since_fall, 3);
        chk(p_oe && ad_oe && ad_out == p_ad, "R6", int'(ad_out), int'(p_ad));
        wr_seen = ad_out; wr_addr_seen = lat_addr; sw = 0; gap_data = 1;
      end
      if (!wr_n) begin
        sw++;
        chk(!ale && addr_hi == lat_addr[15:8], "R7", int'(ale), 0);
      end
      if (wr_n && !p_wr) begin
        chk(sw == 6, "R6", sw, 6);
        chk(ad_oe && ad_out == wr_seen, "R6", int'(ad_out), int'(wr_seen));
      end
      // completions
      if (done) begin
        case (done_op)
          2'd0: begin
            chk(!p_psen && psen_n, "R4", int'(p_psen), 0);
            chk(done_rdata == memf(lat_addr), "R4", int'(done_rdata), int'(memf(lat_addr)));
            if (q.size() > 0 && q[0].op == 2'd0 && q[0].addr == lat_addr) void'(q.pop_front());
            else chk(lat_addr == last_fetch + 16'd1, "R10", int'(lat_addr), int'(last_fetch + 16'd1));
            last_fetch = lat_addr;
          end
          2'd1: begin
            chk(!p_rd && rd_n, "R5", int'(p_rd), 0);
            chk(done_rdata == memf(lat_addr), "R5", int'(done_rdata), int'(memf(lat_addr)));
            if (q.size() == 0) chk(0, "R9", 1, 0);
            else begin
              chk(q[0].op == 2'd1 && q[0].addr == lat_addr, "R9", int'(lat_addr), int'(q[0].addr));
              void'(q.pop_front());
            end
          end
          default: begin
            if (q.size() == 0) chk(0, "R9", 2, 0);
            else begin
              chk(q[0].op == 2'd2 && q[0].addr == wr_addr_seen, "R6", int'(wr_addr_seen), int'(q[0].addr));
              chk(q[0].data == wr_seen, "R6", int'(wr_seen), int'(q[0].data));
              void'(q.pop_front());
            end
          end
        endcase
      end
      p_ale = ale; p_psen = psen_n; p_rd = rd_n; p_wr = wr_n; p_oe = ad_oe; p_ad = ad_out;
    end
  end

  // driver: waits for the accept clock, then pushes the expected item
  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    @(posedge clk);
    e.op = (op == 2'd3) ? 2'd0 : op; e.addr = a; e.data = d;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
    chk(ale && busy, "R9", int'({ale, busy}), 3);
  endtask

  task automatic wait_idx(input int m);
    do @(negedge clk); while ((idx % 12) != m);
  endtask

  task automatic port_sample(input logic [7:0] v);
    wait_idx(8); port_pins = ~v;
    wait_idx(9); port_pins = v;
    wait_idx(10); port_pins = ~v;
    chk(port_smp == v, "R11", int'(port_smp), int'(v));
    wait_idx(8);
    chk(port_smp == v, "R11", int'(port_smp), int'(v));
  endtask

  task automatic port_write(input logic [7:0] d);
    logic [7:0] old;
    old = port_out;
    wait_idx(3); port_wr_en = 1; port_wr_data = d;
    wait_idx(4); port_wr_en = 0;
    wait_idx(11);
    chk(port_out == old, "R12", int'(port_out), int'(old));
    wait_idx(0);
    chk(port_out == d, "R12", int'(port_out), int'(d));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(ale && psen_n && rd_n && wr_n, "R13", int'({ale, psen_n, rd_n, wr_n}), 15);
    chk(busy && !done, "R13", int'({busy, done}), 2);
    chk(port_out == 8'hFF, "R13", int'(port_out), 255);
    rst = 0;
    repeat (40) @(negedge clk);
    issue(2'd1, 16'h1234, 8'h00);
    issue(2'd2, 16'hABCD, 8'h5A);
    issue(2'd0, 16'h8000, 8'h00);
    repeat (20) @(negedge clk);
    issue(2'd1, 16'h00FF, 8'h00);
    issue(2'd2, 16'hFFFF, 8'h00);
    issue(2'd1, 16'h7E81, 8'h00);
    issue(2'd3, 16'h4000, 8'h00);
    issue(2'd2, 16'h0102, 8'hC3);
    repeat (30) @(negedge clk);
    for (int k = 0; k < 200 && q.size() > 0; k++) @(negedge clk);
    chk(q.size() == 0, "R9", q.size(), 0);
    port_sample(8'hA5);
    port_sample(8'h3C);
    port_write(8'h12);
    port_write(8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule